// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide Drive Data Bridge

This block lets a host with an 8-bit data bus use the full 16-bit data register of a parallel ATA drive. No drive capacity is lost. The host reaches the drive through a small window of ports. One port reaches the low byte of the drive's data register. One port reaches a high-byte holding register. The remaining ports map one-to-one onto the drive's 8-bit command, status and task-file registers.

Moving one 16-bit word takes two host accesses:
- **Write:** the host stages the high byte in a write-direction holding register. The next low-byte write starts a single 16-bit write strobe to the drive.
- **Read:** a low-byte read starts a 16-bit read strobe and returns the low byte. At the same time it captures the high byte into a separate read-direction holding register, which the next high-byte read returns.

A small one-hot sequencer follows the byte accesses and selects which holding register feeds the host. All data moves by programmed I/O.

Drive-side outputs:
- active-low read and write strobes, each held for a fixed number of clocks;
- a register-select field;
- a 16-bit data output with separate output enables for the low and high lanes.

Top module: `ata_byte_bridge`

## Requirements
- R1: After reset both strobes are high (inactive), both output enables are off, `host_busy_o` and `host_rvalid_o` are low, and a high-port read returns 0x00.
- R2: The high port is any address with bit 3 set. A host write there stores the byte in the write holding register and produces no drive strobe and no busy.
- R3: A host write to address 0 produces exactly one write strobe. The strobe is low for STROBE_CYC clocks, starting the clock after the access is accepted. During the strobe, `drv_reg_o` is 0, `drv_data_o` is {staged high byte, written low byte}, and both lane enables are on (`drv_data_oe_o` = 2'b11).
- R4: A low-byte write with no new high-byte write since the previous one reuses the last staged high byte.
- R5: A host read of address 0 produces one read strobe, low for STROBE_CYC clocks. On the clock after the strobe ends, `host_rvalid_o` pulses with `drv_data_i[7:0]`, and `drv_data_i[15:8]` is captured in the read holding register.
- R6: A high-port read that directly follows a low-byte read returns the captured high byte. `host_rvalid_o` pulses on the clock after acceptance.
- R7: A high-port read in any other sequencer state returns the write holding register. Any access that is not a high-port write, and not a low-byte read, returns the sequencer to its idle state.
- R8: Addresses 1 to 7 are 8-bit task-file registers, and each is one host access. A write drives only the low lane (`drv_data_oe_o` = 2'b01). A read returns `drv_data_i[7:0]`. `drv_reg_o` equals the address. Neither holding register changes.
- R9: The data output enables are on only while the write strobe is low, and the read and write strobes are never low together.
- R10: A host request made while `host_busy_o` is high is ignored.
- R11: Bits 2:0 of the address do not matter for the high port, so address 0xF behaves exactly like 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request, one access per accepted cycle |
| host_we_i | input | 1 | 1 = host write, 0 = host read |
| host_addr_i | input | 4 | Port address within the window |
| host_wdata_i | input | 8 | Host write byte |
| host_busy_o | output | 1 | Drive strobe in progress; requests are ignored |
| host_rvalid_o | output | 1 | Read data valid pulse |
| host_rdata_o | output | 8 | Read byte |
| drv_reg_o | output | 3 | Drive register select |
| drv_rd_n_o | output | 1 | Drive read strobe, active low |
| drv_wr_n_o | output | 1 | Drive write strobe, active low |
| drv_data_o | output | 16 | Drive data output |
| drv_data_oe_o | output | 2 | Output enables, bit 0 low lane, bit 1 high lane |
| drv_data_i | input | 16 | Drive data input |

## Verification
The assertions check the following on every cycle:
- the strobes never overlap, and the lanes are driven only inside a write strobe;
- a high-byte write never raises a strobe;
- a busy-time request leaves the staged byte alone;
- the sequencer stays one-hot;
- a high read straight after a low read returns the captured byte.

The bench scenarios are needed for the following:
- the exact 16-bit word placed on the drive;
- the strobe length and register select;
- reuse of a stale high byte;
- which holding register a high read returns after task-file traffic;
- the full effect of ignoring requests during a strobe.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
  typedef enum logic [1:0] {
    PORT_DATA_LO = 2'd0,
    PORT_DATA_HI = 2'd1,
    PORT_TASK    = 2'd2
  } port_e;

  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'b001,
    SEQ_WR_HELD = 3'b010,
    SEQ_RD_HELD = 3'b100
  } seq_e;
endpackage

// File: rtl/ata_bridge_decode.sv
module ata_bridge_decode
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             port_o,
  output logic [REG_W-1:0]  reg_o
);
  localparam int HI_BIT = ADDR_W - 1;

  assign reg_o = addr_i[REG_W-1:0];

  always_comb begin
    if (addr_i[HI_BIT])            port_o = PORT_DATA_HI;
    else if (addr_i[REG_W-1:0] == '0) port_o = PORT_DATA_LO;
    else                           port_o = PORT_TASK;
  end
endmodule

// File: rtl/ata_bridge_seq.sv
module ata_bridge_seq
  import ata_bridge_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  logic  we_i,
  input  port_e port_i,
  output seq_e  state_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (acc_i) begin
      unique case (port_i)
        PORT_DATA_HI: state_d = we_i ? SEQ_WR_HELD : SEQ_IDLE;
        PORT_DATA_LO: state_d = we_i ? SEQ_IDLE : SEQ_RD_HELD;
        default:      state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_seq_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  // R6: a low-byte read arms the captured high byte for the next host access
  assert_rd_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && port_i == PORT_DATA_LO) |=> state_q == SEQ_RD_HELD);
endmodule

// File: rtl/ata_bridge_strobe.sv
module ata_bridge_strobe #(
  parameter int STROBE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(STROBE_CYC - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == '0);

  assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !start_i);

  assert_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !active_o);
endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BYTE_W     = 8,
  parameter int REG_W      = 3,
  parameter int STROBE_CYC = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_req_i,
  input  logic                host_we_i,
  input  logic [ADDR_W-1:0]   host_addr_i,
  input  logic [BYTE_W-1:0]   host_wdata_i,
  output logic                host_busy_o,
  output logic                host_rvalid_o,
  output logic [BYTE_W-1:0]   host_rdata_o,
  output logic [REG_W-1:0]    drv_reg_o,
  output logic                drv_rd_n_o,
  output logic                drv_wr_n_o,
  output logic [2*BYTE_W-1:0] drv_data_o,
  output logic [1:0]          drv_data_oe_o,
  input  logic [2*BYTE_W-1:0] drv_data_i
);
  localparam int WORD_W = 2 * BYTE_W;

  port_e            port;
  logic [REG_W-1:0] reg_sel;
  seq_e             seq_state;
  logic             acc, start_drv, active, last;

  logic             op_we_q;
  port_e            op_port_q;
  logic [REG_W-1:0] op_reg_q;
  logic [BYTE_W-1:0] lo_q, wr_hi_q, rd_hi_q, rdata_q;
  logic             rvalid_q;

  assign acc       = host_req_i && !active;
  assign start_drv = acc && (port != PORT_DATA_HI);

  ata_bridge_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_decode (
    .addr_i (host_addr_i),
    .port_o (port),
    .reg_o  (reg_sel)
  );

  ata_bridge_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .we_i    (host_we_i),
    .port_i  (port),
    .state_o (seq_state)
  );

  ata_bridge_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_drv),
    .active_o (active),
    .last_o   (last)
  );

  // operation latched for the duration of the drive strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q   <= 1'b0;
      op_port_q <= PORT_DATA_LO;
      op_reg_q  <= '0;
      lo_q      <= '0;
    end else if (start_drv) begin
      op_we_q   <= host_we_i;
      op_port_q <= port;
      op_reg_q  <= reg_sel;
      lo_q      <= host_wdata_i;
    end
  end

  // write-direction high byte: enabled only for writes (read gates it off)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          wr_hi_q <= '0;
    else if (acc && host_we_i && port == PORT_DATA_HI)    wr_hi_q <= host_wdata_i;
  end

  // read-direction high byte: captured at the end of a data-word read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          rd_hi_q <= '0;
    else if (last && !op_we_q && op_port_q == PORT_DATA_LO)
      rd_hi_q <= drv_data_i[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      if (acc && !host_we_i && port == PORT_DATA_HI) begin
        rvalid_q <= 1'b1;
        rdata_q  <= (seq_state == SEQ_RD_HELD) ? rd_hi_q : wr_hi_q;
      end else if (last && !op_we_q) begin
        rvalid_q <= 1'b1;
        rdata_q  <= drv_data_i[BYTE_W-1:0];
      end
    end
  end

  assign host_busy_o   = active;
  assign host_rvalid_o = rvalid_q;
  assign host_rdata_o  = rdata_q;
  assign drv_reg_o     = op_reg_q;
  assign drv_rd_n_o    = !(active && !op_we_q);
  assign drv_wr_n_o    = !(active && op_we_q);
  assign drv_data_o    = {wr_hi_q, lo_q};
  assign drv_data_oe_o = (active && op_we_q) ? {op_port_q == PORT_DATA_LO, 1'b1} : 2'b00;

  assert_no_fight_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!drv_rd_n_o && !drv_wr_n_o));

  assert_oe_in_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_data_oe_o != 2'b00) |-> !drv_wr_n_o);

  assert_hi_wr_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && host_we_i && port == PORT_DATA_HI) |=> (drv_rd_n_o && drv_wr_n_o));

  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_busy_o && host_req_i) |=> $stable(wr_hi_q));

  assert_rd_hi_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !host_we_i && port == PORT_DATA_HI && seq_state == SEQ_RD_HELD)
      |=> (host_rvalid_o && host_rdata_o == $past(rd_hi_q)));

  assert_word_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_wr_n_o && $past(!drv_wr_n_o)) |-> $stable(drv_data_o));
endmodule

// File: tb/sim_ata_byte_bridge.sv
`timescale 1ns/1ps
module sim_ata_byte_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, rvalid, rd_n, wr_n;
  logic [7:0]  rdata;
  logic [2:0]  rsel;
  logic [15:0] dout, din = '0;
  logic [1:0]  oe;

  int checks = 0, errors = 0;
  bit oe_bad = 1'b0;

  always #2.5 clk = ~clk;

  ata_byte_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_busy_o(busy),
    .host_rvalid_o(rvalid), .host_rdata_o(rdata), .drv_reg_o(rsel),
    .drv_rd_n_o(rd_n), .drv_wr_n_o(wr_n), .drv_data_o(dout),
    .drv_data_oe_o(oe), .drv_data_i(din)
  );

  always @(negedge clk) if (rst_n && oe != 2'b00 && wr_n) oe_bad = 1'b1;

  task automatic chk(input bit ok, input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [15:0] din;
    logic [3:0]  wrc;
    logic [3:0]  rdc;
    logic [15:0] expv;
    logic [1:0]  oe;
    logic [2:0]  rg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h8, 8'hA5, 16'h0000, 4'd0, 4'd0, 16'h0000, 2'b00, 3'd0}, // R2 stage high
    '{1'b1, 4'h0, 8'h3C, 16'h0000, 4'd3, 4'd0, 16'hA53C, 2'b11, 3'd0}, // R3 word write
    '{1'b1, 4'h0, 8'h11, 16'h0000, 4'd3, 4'd0, 16'hA511, 2'b11, 3'd0}, // R4 stale high
    '{1'b0, 4'h8, 8'h00, 16'h0000, 4'd0, 4'd0, 16'h00A5, 2'b00, 3'd0}, // R7 idle high read
    '{1'b0, 4'h0, 8'h00, 16'hBEEF, 4'd0, 4'd3, 16'h00EF, 2'b00, 3'd0}, // R5 word read
    '{1'b0, 4'h8, 8'h00, 16'h0000, 4'd0, 4'd0, 16'h00BE, 2'b00, 3'd0}, // R6 captured high
    '{1'b0, 4'h8, 8'h00, 16'h0000, 4'd0, 4'd0, 16'h00A5, 2'b00, 3'd0}, // R7 back to write reg
    '{1'b1, 4'h7, 8'hEC, 16'h0000, 4'd3, 4'd0, 16'h00EC, 2'b01, 3'd7}, // R8 task write
    '{1'b0, 4'h1, 8'h00, 16'h1234, 4'd0, 4'd3, 16'h0034, 2'b00, 3'd1}, // R8 task read
    '{1'b0, 4'h8, 8'h00, 16'h0000, 4'd0, 4'd0, 16'h00A5, 2'b00, 3'd0}, // R8 high reg kept
    '{1'b1, 4'h0, 8'h00, 16'h0000, 4'd3, 4'd0, 16'hA500, 2'b11, 3'd0}, // R8 word after task
    '{1'b1, 4'hF, 8'h5A, 16'h0000, 4'd0, 4'd0, 16'h0000, 2'b00, 3'd0}, // R11 alias high
    '{1'b0, 4'h8, 8'h00, 16'h0000, 4'd0, 4'd0, 16'h005A, 2'b00, 3'd0}  // R11 readback
  };

  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d,
                        output int wrc, output int rdc, output logic [15:0] wd,
                        output logic [1:0] o, output logic [2:0] rg,
                        output bit got, output logic [7:0] rd);
    wrc = 0; rdc = 0; wd = '0; o = '0; rg = '0; got = 1'b0; rd = '0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (!wr_n) begin wrc++; wd = dout; o = oe; rg = rsel; end
      if (!rd_n) begin rdc++; rg = rsel; end
      if (rvalid) begin got = 1'b1; rd = rdata; end
      if (!busy && (w || got)) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wrc, rdc;
    logic [15:0] wd;
    logic [1:0] o;
    logic [2:0] rg;
    bit got;
    logic [7:0] rd;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 2'b11);
    chk(oe == 2'b00 && !busy && !rvalid, "R1 idle outputs", {oe, busy, rvalid}, 0);
    rst_n = 1'b1;
    access(1'b0, 4'h8, 8'h00, wrc, rdc, wd, o, rg, got, rd);
    chk(got && rd == 8'h00, "R1 high read after reset", rd, 8'h00);

    foreach (VECS[i]) begin
      din = VECS[i].din;
      access(VECS[i].we, VECS[i].addr, VECS[i].wdata, wrc, rdc, wd, o, rg, got, rd);
      chk(wrc == VECS[i].wrc, $sformatf("vec%0d write strobe len", i), wrc, VECS[i].wrc);
      chk(rdc == VECS[i].rdc, $sformatf("vec%0d read strobe len", i), rdc, VECS[i].rdc);
      if (VECS[i].we && VECS[i].wrc != 0) begin
        if (VECS[i].oe == 2'b11)
          chk(wd == VECS[i].expv, $sformatf("vec%0d drive word", i), wd, VECS[i].expv);
        else
          chk(wd[7:0] == VECS[i].expv[7:0], $sformatf("vec%0d drive byte", i), wd[7:0], VECS[i].expv[7:0]);
        chk(o == VECS[i].oe, $sformatf("vec%0d lane enables", i), o, VECS[i].oe);
      end
      if (!VECS[i].we)
        chk(got && rd == VECS[i].expv[7:0], $sformatf("vec%0d read byte", i), rd, VECS[i].expv[7:0]);
      if (VECS[i].wrc != 0 || VECS[i].rdc != 0)
        chk(rg == VECS[i].rg, $sformatf("vec%0d register select", i), rg, VECS[i].rg);
    end

    // R10: request during busy is dropped
    begin
      int n = 0;
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 4'h0; wdata = 8'h77;
      @(negedge clk);
      addr = 4'h8; wdata = 8'hFF;
      if (!wr_n) n++;
      @(negedge clk);
      if (!wr_n) n++;
      @(negedge clk);
      req = 1'b0;
      if (!wr_n) n++;
      chk(dout == 16'h5A77, "R10 word during busy", dout, 16'h5A77);
      repeat (4) begin @(negedge clk); if (!wr_n) n++; end
      chk(n == 3, "R10 single strobe", n, 3);
      access(1'b0, 4'h8, 8'h00, wrc, rdc, wd, o, rg, got, rd);
      chk(rd == 8'h5A, "R10 staged byte untouched", rd, 8'h5A);
    end

    chk(!oe_bad, "R9 enables outside write strobe", oe_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule